// File: doc/BRIEF.md
# Costas Arm Lock and Power Detector

This block takes the filtered in-phase and quadrature arm samples of a Costas carrier loop and derives two indications from them. Each arm sample is squared, the square is scaled down, and each scaled square is smoothed by its own single-pole low-pass filter. The two smoothed powers are combined in two ways:

- Their difference behaves like the cosine of twice the phase error. It peaks when the loop has pulled in, so it serves as the lock measure.
- Their sum tracks the total input power.

A flag compares the lock measure with a fixed threshold. This lets the surrounding loop switch from its wide acquisition filter to its narrow tracking filter.

Samples arrive with a valid strobe, and all state advances only on strobed samples. Both outputs are signed and saturate at the limits of their width. The filter state starts from zero, so both outputs rise from zero after reset.

Top module: `costas_lock_power_det`

## Requirements
- R1: While reset is asserted, and on the first cycle after its release, `lock_det`, `power_det` and `lock_flag` are all zero.
- R2: Each arm sample s (signed, 16 bits) is reduced to x = floor(s*s / 32768) before filtering. A full-scale sample of -32768 gives x = 32768.
- R3: A cycle with `in_valid` low changes neither output nor the flag, whatever the arm inputs carry.
- R4: On each valid sample, each arm's smoothed power y moves to y + floor((x - y) * 954 / 32768). Here 954 is one minus the pole coefficient 31814/32768 (about 0.9709). The smoothed power never goes negative.
- R5: `lock_det` equals the smoothed I power minus the smoothed Q power, as a signed 16-bit value saturated to the range -32768..32767. It never exceeds `power_det`.
- R6: `power_det` equals the sum of the two smoothed powers, as a signed 16-bit value saturated at 32767. It is never negative.
- R7: On each valid sample, `lock_flag` is set when the updated `lock_det` is 9950 or more and cleared otherwise. Between valid samples it holds its value.
- R8: A sample presented with `in_valid` high shows up on `lock_det`, `power_det` and `lock_flag` just after the next rising clock edge, and not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Arm samples are valid this cycle |
| arm_i | input | 16 | Filtered in-phase arm sample, signed |
| arm_q | input | 16 | Filtered quadrature arm sample, signed |
| lock_det | output | 16 | Smoothed I power minus smoothed Q power, signed, saturated |
| power_det | output | 16 | Smoothed I power plus smoothed Q power, signed, saturated |
| lock_flag | output | 1 | Lock measure at or above threshold |

## Verification
The assertions assume that `in_valid` and the arm samples are driven to known values once reset is released, and that every signed 16-bit value, -32768 included, is a legal sample. The stimulus changes inputs only on falling edges and holds them over each rising edge. It covers the full signed range, with both arms at -32768 and runs long enough for the power sum to saturate. It also includes idle stretches where the arm inputs take arbitrary values while the strobe is low.

// File: rtl/costas_lock_power_det.sv
module costas_lock_power_det #(
  parameter int W      = 16,
  parameter int SHIFT  = 15,
  parameter int COEF   = 31814,
  parameter int THRESH = 9950,
  parameter int OUT_W  = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic signed [W-1:0]     arm_i,
  input  logic signed [W-1:0]     arm_q,
  output logic signed [OUT_W-1:0] lock_det,
  output logic signed [OUT_W-1:0] power_det,
  output logic                    lock_flag
);

  localparam int SW  = 2*W - SHIFT + 1;
  localparam int PW  = SW + SHIFT + 2;
  localparam logic signed [PW-1:0] ALPHA = PW'((1 << SHIFT) - COEF);
  localparam logic signed [SW:0] MAXV = (SW+1)'((1 << (OUT_W-1)) - 1);
  localparam logic signed [SW:0] MINV = -MAXV - 1;

  logic signed [2*W-1:0] sq_i, sq_q;
  logic signed [SW-1:0]  x_i, x_q, y_i, y_q, yn_i, yn_q;
  logic signed [SW:0]    d_i, d_q;
  logic signed [PW-1:0]  p_i, p_q, s_i, s_q;
  logic signed [OUT_W-1:0] lock_next;

  function automatic logic signed [OUT_W-1:0] sat(input logic signed [SW:0] v);
    if (v > MAXV)      return MAXV[OUT_W-1:0];
    else if (v < MINV) return MINV[OUT_W-1:0];
    else               return v[OUT_W-1:0];
  endfunction

  assign sq_i = arm_i * arm_i;
  assign sq_q = arm_q * arm_q;
  assign x_i  = {1'b0, sq_i[2*W-1:SHIFT]};
  assign x_q  = {1'b0, sq_q[2*W-1:SHIFT]};

  assign d_i  = {x_i[SW-1], x_i} - {y_i[SW-1], y_i};
  assign d_q  = {x_q[SW-1], x_q} - {y_q[SW-1], y_q};
  assign p_i  = {{(PW-SW-1){d_i[SW]}}, d_i} * ALPHA;
  assign p_q  = {{(PW-SW-1){d_q[SW]}}, d_q} * ALPHA;
  assign s_i  = p_i >>> SHIFT;
  assign s_q  = p_q >>> SHIFT;
  assign yn_i = y_i + s_i[SW-1:0];
  assign yn_q = y_q + s_q[SW-1:0];

  assign lock_next = sat({yn_i[SW-1], yn_i} - {yn_q[SW-1], yn_q});
  assign lock_det  = sat({y_i[SW-1], y_i} - {y_q[SW-1], y_q});
  assign power_det = sat({y_i[SW-1], y_i} + {y_q[SW-1], y_q});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      y_i       <= '0;
      y_q       <= '0;
      lock_flag <= 1'b0;
    end else if (in_valid) begin
      y_i       <= yn_i;
      y_q       <= yn_q;
      lock_flag <= (lock_next >= THRESH);
    end
  end

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(lock_det) && $stable(power_det) && $stable(lock_flag)));

  assert_flag_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (lock_flag == (lock_det >= THRESH)));

  assert_state_nonneg_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !y_i[SW-1] && !y_q[SW-1]);

  assert_lock_le_power_R5: assert property (@(posedge clk) disable iff (!rst_n)
    lock_det <= power_det);

  assert_power_nonneg_R6: assert property (@(posedge clk) disable iff (!rst_n)
    power_det >= 0);

endmodule

// File: tb/sim_costas_lock_power_det.sv
module sim_costas_lock_power_det;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic signed [15:0] arm_i = '0, arm_q = '0;
  logic signed [15:0] lock_det, power_det;
  logic lock_flag;

  int n_checks = 0, n_fail = 0;
  int m_yi = 0, m_yq = 0;
  bit m_flag = 0;
  bit done = 0;

  always #2 clk = ~clk;

  costas_lock_power_det u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .arm_i(arm_i), .arm_q(arm_q),
    .lock_det(lock_det), .power_det(power_det), .lock_flag(lock_flag)
  );

  // each entry: {arm_i, arm_q, number of valid samples}
  localparam logic [47:0] VEC [8] = '{
    {16'sd20000,  16'sd0,      16'd200},
    {16'sd0,      16'sd20000,  16'd300},
    {16'sd30000,  16'sd30000,  16'd400},
    {-16'sd25000, 16'sd3000,   16'd100},
    {16'sd0,      16'sd0,      16'd50},
    {-16'sd32768, -16'sd32768, 16'd300},
    {16'sd12000,  -16'sd12000, 16'd30},
    {16'sd32767,  16'sd100,    16'd500}
  };

  function automatic int sat16(input int v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  function automatic int flt(input int y, input int s);
    int x;
    x = (s * s) / 32768;
    return y + (((x - y) * 954) >>> 15);
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    check(req, "lock_det", int'(lock_det), sat16(m_yi - m_yq));
    check(req, "power_det", int'(power_det), sat16(m_yi + m_yq));
    check(req, "lock_flag", int'(lock_flag), int'(m_flag));
  endtask

  task automatic step(input logic signed [15:0] si, input logic signed [15:0] sq);
    arm_i = si; arm_q = sq; in_valid = 1'b1;
    @(negedge clk);
    m_yi = flt(m_yi, int'(si));
    m_yq = flt(m_yq, int'(sq));
    m_flag = (sat16(m_yi - m_yq) >= 9950);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; in_valid = 1'b0;
    m_yi = 0; m_yq = 0; m_flag = 0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    check("R1", "lock_det in reset", int'(lock_det), 0);
    check("R1", "power_det in reset", int'(power_det), 0);
    check("R1", "lock_flag in reset", int'(lock_flag), 0);
    do_reset();
    check_all("R1");

    // R8: nothing visible before the edge, first filter step after it
    arm_i = 16'sd20000; arm_q = 16'sd0; in_valid = 1'b1;
    #1;
    check("R8", "lock_det before edge", int'(lock_det), 0);
    @(negedge clk);
    in_valid = 1'b0;
    check("R8", "lock_det after edge", int'(lock_det), 355);
    check("R2", "power_det first step", int'(power_det), 355);
    m_yi = 355;

    do_reset();
    // R2/R4/R5/R6/R7 walked through the vector table
    foreach (VEC[k]) begin
      for (int n = 0; n < int'(VEC[k][15:0]); n++)
        step(VEC[k][47:32], VEC[k][31:16]);
      check_all($sformatf("R4 R5 R6 R7 vector %0d", k));
    end
    in_valid = 1'b0;

    // R3: strobe low, wild inputs, nothing moves
    arm_i = -16'sd32768; arm_q = 16'sd32767;
    repeat (6) @(negedge clk);
    check_all("R3");

    // R6: power saturation at 32767 from both arms at 30000
    do_reset();
    repeat (300) step(16'sd30000, 16'sd30000);
    in_valid = 1'b0;
    check("R6", "power_det saturated", int'(power_det), 32767);
    check("R5", "lock_det zero for equal arms", int'(lock_det), 0);

    // R2: -32768 squared gives 32768; R7 flag rises and then clears
    do_reset();
    repeat (400) step(-16'sd32768, 16'sd0);
    check_all("R2 full-scale");
    check("R7", "flag set", int'(lock_flag), 1);
    repeat (150) step(16'sd0, 16'sd0);
    in_valid = 1'b0;
    check("R7", "flag cleared", int'(lock_flag), 0);
    check_all("R4 decay");

    // R1: mid-run reset clears everything
    repeat (50) step(16'sd20000, 16'sd0);
    in_valid = 1'b0;
    rst_n = 1'b0;
    #1;
    check("R1", "lock_det async reset", int'(lock_det), 0);
    check("R1", "lock_flag async reset", int'(lock_flag), 0);
    do_reset();
    check_all("R1 after release");

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule